// File: doc/BRIEF.md
# Programmable Read/Write Strobe Timing Generator

The block drives the active-low write-enable and output-enable strobes of one external memory access. A start pulse launches the access and latches a 32-bit timing word, the read/write select and the multiplexed-mode flag. A cycle counter then counts functional-clock cycles from the start of the access. Each strobe is low while the count lies inside a programmed window.

Each strobe can be moved half a clock period later. The block does this with a falling-edge copy of its registered value, and the timing word picks the copy per strobe. A read in address/address/data multiplexed mode also has a second output-enable window that covers the first address phase. The access ends with a one-cycle done pulse when the count reaches the latest deassertion time in use.

Top module: `strobe_timing_gen`

## Requirements
- R1: Out of reset both strobes are high (inactive), done is low and the block is idle.
- R2: A start pulse seen while idle latches the timing word, direction and mode. Later changes on those inputs, and a start pulse during an access, have no effect on the access in progress.
- R3: The launch edge is edge 0, and cycle k is the k-th clock period after it. On a write (write_i=1), write-enable is low in cycle k exactly when on <= k < off. Here on is bits 19..16 and off is bits 28..24. Output-enable stays high.
- R4: On a read (write_i=0) with mux_i=0, output-enable is low in cycle k exactly when on <= k < off. Here on is bits 3..0 and off is bits 12..8. Write-enable stays high.
- R5: On a read with mux_i=1, output-enable is also low in cycles where first-phase-on <= k < first-phase-off. First-phase-on is bits 6..4 and first-phase-off is bits 15..13.
- R6: A window whose on time is greater than or equal to its off time never drives its strobe low.
- R7: Bit 23 (write-enable) or bit 7 (output-enable), when set, delays both edges of that strobe by half a clock period with no other change of shape.
- R8: done_o is high for exactly cycle k = end, after which the block is idle. For a write, end is the write-enable off time. For a read, end is the output-enable off time, or the larger of the two output-enable off times in multiplexed mode.
- R9: Bits 31..29 and 22..20 have no effect on the strobes or on done.
- R10: During an access the cycle count rises by one each clock until done.
- R11: The two strobes are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches an access when idle |
| write_i | input | 1 | 1 = write access, 0 = read access |
| mux_i | input | 1 | Address/address/data multiplexed read |
| cfg_i | input | 32 | Strobe timing word |
| we_no | output | 1 | Write-enable strobe, active low |
| oe_no | output | 1 | Output-enable strobe, active low |
| done_o | output | 1 | One-cycle end-of-access pulse |

## Verification
On every cycle the assertions check four things: the count steps by one, the block goes idle after done, the latched word stays stable mid-access, and the two strobes never overlap. They also check that the falling-edge copy tracks the registered strobe and that an empty window keeps its strobe high. The exact placement of each edge against the programmed times can only be seen from the bench's scenarios. The same goes for the half-period shift seen at quarter and three-quarter points, the first-phase window, the end cycle picked by direction and mode, and the inertness of reserved bits.

// File: rtl/strobe_timing_pkg.sv
package strobe_timing_pkg;

  localparam int CNT_W = 5;

  typedef struct packed {
    logic [2:0] rsv_hi;
    logic [4:0] we_off;
    logic       we_half;
    logic [2:0] rsv_mid;
    logic [3:0] we_on;
    logic [2:0] ph1_off;
    logic [4:0] oe_off;
    logic       oe_half;
    logic [2:0] ph1_on;
    logic [3:0] oe_on;
  } timing_cfg_t;

  function automatic logic [CNT_W-1:0] access_end(timing_cfg_t c, logic wr, logic mx);
    logic [CNT_W-1:0] p1;
    p1 = CNT_W'(c.ph1_off);
    if (wr)                 return c.we_off;
    else if (mx && p1 > c.oe_off) return p1;
    else                    return c.oe_off;
  endfunction

endpackage

// File: rtl/stg_window.sv
module stg_window #(
  parameter int CNT_W = 5,
  parameter int ON_W  = 4,
  parameter int OFF_W = 5
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [ON_W-1:0]  on_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             in_win_o
);
  logic [CNT_W-1:0] on_x, off_x;
  assign on_x     = CNT_W'(on_i);
  assign off_x    = CNT_W'(off_i);
  assign in_win_o = (cnt_i >= on_x) && (cnt_i < off_x);
endmodule

// File: rtl/stg_counter.sv
module stg_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] end_i,
  output logic             launch_o,
  output logic             active_n_o,
  output logic [CNT_W-1:0] cnt_n_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign launch_o   = start_i && !busy_q;
  assign done_o     = busy_q && (cnt_q == end_i);
  assign active_n_o = launch_o || (busy_q && !done_o);
  assign busy_o     = busy_q;

  always_comb begin
    cnt_n_o = cnt_q;
    if (launch_o)                cnt_n_o = '0;
    else if (busy_q && !done_o)  cnt_n_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n_o;
      busy_q <= active_n_o;
    end
  end

  // R10
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R8
  idle_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q);
endmodule

// File: rtl/stg_half_shift.sv
module stg_half_shift (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_n_i,
  input  logic half_i,
  output logic strobe_no
);
  logic main_q, half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) main_q <= 1'b1;
    else         main_q <= raw_n_i;
  end

  // falling-edge copy gives the half-period shift without a gated path
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_q <= 1'b1;
    else         half_q <= main_q;
  end

  assign strobe_no = half_i ? half_q : main_q;

  // R7
  half_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_q == main_q);
endmodule

// File: rtl/strobe_timing_gen.sv
module strobe_timing_gen
  import strobe_timing_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        write_i,
  input  logic        mux_i,
  input  logic [31:0] cfg_i,
  output logic        we_no,
  output logic        oe_no,
  output logic        done_o
);
  timing_cfg_t      cfg_q, cfg_n, cfg_in;
  logic             wr_q, wr_n, mx_q, mx_n;
  logic             launch, active_n, busy;
  logic [CNT_W-1:0] cnt_n, end_cnt;
  logic             we_in, oe_in, ph1_in;
  logic             we_raw_n, oe_raw_n;

  assign cfg_in = timing_cfg_t'(cfg_i);

  always_comb begin
    cfg_n = launch ? cfg_in  : cfg_q;
    wr_n  = launch ? write_i : wr_q;
    mx_n  = launch ? mux_i   : mx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      wr_q  <= 1'b0;
      mx_q  <= 1'b0;
    end else begin
      cfg_q <= cfg_n;
      wr_q  <= wr_n;
      mx_q  <= mx_n;
    end
  end

  assign end_cnt = access_end(cfg_q, wr_q, mx_q);

  stg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .start_i,
    .end_i     (end_cnt),
    .launch_o  (launch),
    .active_n_o(active_n),
    .cnt_n_o   (cnt_n),
    .busy_o    (busy),
    .done_o
  );

  stg_window #(.CNT_W(CNT_W), .ON_W(4), .OFF_W(5)) u_we_win (
    .cnt_i(cnt_n), .on_i(cfg_n.we_on), .off_i(cfg_n.we_off), .in_win_o(we_in));
  stg_window #(.CNT_W(CNT_W), .ON_W(4), .OFF_W(5)) u_oe_win (
    .cnt_i(cnt_n), .on_i(cfg_n.oe_on), .off_i(cfg_n.oe_off), .in_win_o(oe_in));
  stg_window #(.CNT_W(CNT_W), .ON_W(3), .OFF_W(3)) u_ph1_win (
    .cnt_i(cnt_n), .on_i(cfg_n.ph1_on), .off_i(cfg_n.ph1_off), .in_win_o(ph1_in));

  assign we_raw_n = !(active_n && wr_n && we_in);
  assign oe_raw_n = !(active_n && !wr_n && (oe_in || (mx_n && ph1_in)));

  stg_half_shift u_we_sh (
    .clk_i, .rst_ni, .raw_n_i(we_raw_n), .half_i(cfg_q.we_half), .strobe_no(we_no));
  stg_half_shift u_oe_sh (
    .clk_i, .rst_ni, .raw_n_i(oe_raw_n), .half_i(cfg_q.oe_half), .strobe_no(oe_no));

  // R11
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !oe_no));
  // R2
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done_o) |=> ($stable(cfg_q) && $stable(wr_q) && $stable(mx_q)));
  // R6
  we_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wr_q && (CNT_W'(cfg_q.we_on) >= cfg_q.we_off)) |-> we_no);
  // R3
  oe_quiet_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wr_q) |-> oe_no);
endmodule

// File: tb/sim_strobe_timing_gen.sv
module sim_strobe_timing_gen;
  localparam int T = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, wr = 1'b0, mx = 1'b0;
  logic [31:0] cfg = '0;
  logic we_n, oe_n, done;
  int   n_run = 0, n_fail = 0;
  bit   finished = 0;

  always #(T/2) clk = ~clk;

  strobe_timing_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .write_i(wr), .mux_i(mx),
    .cfg_i(cfg), .we_no(we_n), .oe_no(oe_n), .done_o(done));

  function automatic int f_end(logic [31:0] c, logic w, logic m);
    if (w) return int'(c[28:24]);
    if (m && c[15:13] > c[12:8]) return int'(c[15:13]);
    return int'(c[12:8]);
  endfunction

  function automatic logic f_raw(logic [31:0] c, logic w, logic m, int k, bit is_we);
    bit lo;
    if (k < 0 || k > f_end(c, w, m)) return 1'b1;
    if (is_we) lo = w && k >= int'(c[19:16]) && k < int'(c[28:24]);
    else lo = !w && ((k >= int'(c[3:0]) && k < int'(c[12:8])) ||
                     (m && k >= int'(c[6:4]) && k < int'(c[15:13])));
    return !lo;
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic access(logic [31:0] c, logic w, logic m, bit inject, string req);
    int e;
    e = f_end(c, w, m);
    @(negedge clk);
    start = 1'b1; cfg = c; wr = w; mx = m;
    @(posedge clk);
    for (int k = 0; k <= e + 1; k++) begin
      #(T/4);
      start = 1'b0;
      cfg = $urandom; wr = $urandom; mx = $urandom;
      if (inject && k == 1 && e >= 2) start = 1'b1; // R2 start while busy
      chk(req, "we_q", we_n, c[23] ? f_raw(c, w, m, k-1, 1) : f_raw(c, w, m, k, 1));
      chk(req, "oe_q", oe_n, c[7]  ? f_raw(c, w, m, k-1, 0) : f_raw(c, w, m, k, 0));
      chk("R8", "done", done, (k == e));
      #(T/2);
      chk(req, "we_h", we_n, f_raw(c, w, m, k, 1));
      chk(req, "oe_h", oe_n, f_raw(c, w, m, k, 0));
      @(posedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0017));
    #(T*3);
    // R1
    chk("R1", "we reset", we_n, 1'b1);
    chk("R1", "oe reset", oe_n, 1'b1);
    chk("R1", "done reset", done, 1'b0);
    rst_n = 1'b1;
    #(T*2);
    chk("R1", "done idle", done, 1'b0);
    // R3 write window 2..6, no delay
    access({3'd0, 5'd6, 1'b0, 3'd0, 4'd2, 3'd0, 5'd0, 1'b0, 3'd0, 4'd0}, 1'b1, 1'b0, 0, "R3");
    // R4 read window 1..9
    access({3'd0, 5'd0, 1'b0, 3'd0, 4'd0, 3'd0, 5'd9, 1'b0, 3'd0, 4'd1}, 1'b0, 1'b0, 0, "R4");
    // R5 mux read: phase1 0..3, main 5..8
    access({3'd0, 5'd0, 1'b0, 3'd0, 4'd0, 3'd3, 5'd8, 1'b0, 3'd0, 4'd5}, 1'b0, 1'b1, 0, "R5");
    // R5/R8 phase1 ends after main window
    access({3'd0, 5'd0, 1'b0, 3'd0, 4'd0, 3'd7, 5'd4, 1'b0, 3'd2, 4'd1}, 1'b0, 1'b1, 0, "R5");
    // R6 empty windows
    access({3'd0, 5'd3, 1'b0, 3'd0, 4'd9, 3'd0, 5'd0, 1'b0, 3'd0, 4'd0}, 1'b1, 1'b0, 0, "R6");
    access({3'd0, 5'd0, 1'b0, 3'd0, 4'd0, 3'd0, 5'd4, 1'b0, 3'd0, 4'd4}, 1'b0, 1'b0, 0, "R6");
    // R7 half delays
    access({3'd0, 5'd5, 1'b1, 3'd0, 4'd0, 3'd0, 5'd0, 1'b0, 3'd0, 4'd0}, 1'b1, 1'b0, 0, "R7");
    access({3'd0, 5'd0, 1'b0, 3'd0, 4'd0, 3'd2, 5'd7, 1'b1, 3'd0, 4'd3}, 1'b0, 1'b1, 0, "R7");
    // R8 zero-length access, max length access
    access(32'h0, 1'b1, 1'b0, 0, "R8");
    access({3'd0, 5'd31, 1'b0, 3'd0, 4'd15, 3'd0, 5'd0, 1'b0, 3'd0, 4'd0}, 1'b1, 1'b0, 0, "R8");
    // R9 reserved bits set
    access({3'd7, 5'd6, 1'b0, 3'd7, 4'd2, 3'd0, 5'd0, 1'b0, 3'd0, 4'd0}, 1'b1, 1'b0, 0, "R9");
    access({3'd7, 5'd0, 1'b0, 3'd7, 4'd0, 3'd1, 5'd5, 1'b1, 3'd0, 4'd2}, 1'b0, 1'b1, 0, "R9");
    // R2 start during access ignored
    access({3'd0, 5'd0, 1'b0, 3'd0, 4'd0, 3'd0, 5'd8, 1'b0, 3'd0, 4'd3}, 1'b0, 1'b0, 1, "R2");
    // random mix (R10 R11 checked along the way)
    for (int i = 0; i < 200; i++)
      access($urandom, 1'($urandom), 1'($urandom), 1'($urandom), "R10");
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(T*150000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule